// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog for a chip that must recover by itself when its software stops responding. A 12-bit down counter runs from the watchdog's own low-speed clock through a programmable prescaler. Software keeps it alive by writing a refresh key to a key register at regular intervals. If the counter runs out first, the block emits a one-cycle reset pulse, loads the counter with its maximum value and keeps counting.

Software starts the watchdog with a start key. A strap input can instead make it run directly out of reset. Once it runs, nothing but a system reset stops it. The divider and reload registers are write-protected. They accept a write only after an unlock key has been written. Any other key, including the refresh key, locks them again.

Each accepted configuration write raises a busy flag in the status register. The flag stays up for a fixed number of prescaled ticks. While it is up, further writes to that register are dropped.

Top module: `keyed_wdt`

## Requirements
- R1: After reset with the strap low: no pulse is issued, the divider register (select 1) reads 0, the reload register (select 2) reads 0xFFF, and the status register (select 3) reads 0.
- R2: Writing 0xCCCC to the key register (select 0) starts the watchdog. With divide ratio D, the pulse comes exactly 4096·D clock cycles after the clock edge that takes the write.
- R3: While the watchdog has not been started and the strap is low, no reset pulse is ever issued.
- R4: Writing 0xAAAA to the key register while the watchdog runs loads the reload value R into the counter and restarts the prescaler. The pulse then follows exactly (R+1)·D cycles after that write edge.
- R5: Writes to the divider and reload registers are accepted only when the most recent key written was 0x5555. Otherwise the register keeps its value.
- R6: After an unlock, writing any key other than 0x5555 locks both configuration registers again. This includes the refresh key 0xAAAA.
- R7: The 3-bit divider code n gives D = 4·2^n for n from 0 to 6. Code 7 gives D = 256.
- R8: Status bit 0 (divider busy) and bit 1 (reload busy) read 1 from the cycle after an accepted write. Each clears within 2·D cycles, and a write to a register whose busy bit is set is dropped.
- R9: With the strap input high during reset, the watchdog runs without any key. The first pulse comes exactly 4096·D cycles after reset is released.
- R10: Once running, the watchdog cannot be stopped by any key. Each pulse lasts one cycle, and the next pulse follows 4096·D cycles later unless a refresh intervenes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_start_i | input | 1 | Strap: run from reset without a start key |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write select: 0 key, 1 divider, 2 reload |
| wr_data_i | input | 16 | Write data |
| rd_sel_i | input | 2 | Read select: 1 divider, 2 reload, 3 status |
| rd_data_o | output | 16 | Read data (combinational) |
| wdt_rst_o | output | 1 | One-cycle reset pulse on expiry |

## Verification
The bench drives each write half a cycle before the taking edge and counts edges from that edge onward. The pulse is due after exactly D·(R+1) edges following a refresh, and D·4096 edges after a start or a reset release. The bench checks that the output is low on every earlier sample, high on that exact sample, and low again on the next one. Register readback and the busy bits are due one cycle after the write. Busy release is polled against a bound of 2·D cycles.

// File: rtl/wdt_pkg.sv
// Package: shared constants for the keyed watchdog.
// Assumes a 16-bit register bus with a 2-bit register select.
package wdt_pkg;
    localparam int          BUS_W      = 16;
    localparam logic [15:0] KEY_RUN    = 16'hCCCC;
    localparam logic [15:0] KEY_FEED   = 16'hAAAA;
    localparam logic [15:0] KEY_OPEN   = 16'h5555;
    localparam logic [1:0]  SEL_KEY    = 2'd0;
    localparam logic [1:0]  SEL_DIV    = 2'd1;
    localparam logic [1:0]  SEL_RELOAD = 2'd2;
    localparam logic [1:0]  SEL_STAT   = 2'd3;
endpackage

// File: rtl/wdt_prescaler.sv
// Module: wdt_prescaler
// Divides the watchdog clock by 2^(BASE_LOG+min(code,SHIFT_MAX)) and emits
// a one-cycle tick at the end of each period. A clear restarts the period.
// Assumes BASE_LOG >= 1, so a tick can never follow a clear directly.
module wdt_prescaler #(
    parameter int CODE_W    = 3,
    parameter int BASE_LOG  = 2,
    parameter int SHIFT_MAX = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              tick_o
);
    localparam int CNT_W = BASE_LOG + SHIFT_MAX;

    logic [CNT_W-1:0] pre_cnt;
    logic [CNT_W-1:0] last_val;
    int               shift;

    // Terminal count of the selected period; codes above SHIFT_MAX saturate.
    always_comb begin
        shift    = (int'(code_i) > SHIFT_MAX) ? SHIFT_MAX : int'(code_i);
        last_val = CNT_W'((1 << (BASE_LOG + shift)) - 1);
    end

    // A shrinking ratio can leave the count above the new terminal value.
    assign tick_o = (pre_cnt >= last_val);

    // Period counter: cleared on reset or on request, wraps at each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) pre_cnt <= '0;
        else if (tick_o)       pre_cnt <= '0;
        else                   pre_cnt <= pre_cnt + 1'b1;
    end

    AST_NO_TICK_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !tick_o); // R7
endmodule

// File: rtl/wdt_down_counter.sv
// Module: wdt_down_counter
// Timeout counter. It holds its maximum while idle, loads on refresh and
// counts down one step per prescaled tick. When a tick arrives at zero it
// issues a one-cycle expiry pulse and rearms at the maximum.
// Assumes a refresh takes priority over a coincident tick.
module wdt_down_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expire_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt;

    // Count, reload and expiry pulse generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= CNT_MAX;
            expire_o <= 1'b0;
        end else begin
            expire_o <= 1'b0;
            if (run_i && load_i) begin
                cnt <= load_val_i;
            end else if (run_i && tick_i) begin
                if (cnt == '0) begin
                    expire_o <= 1'b1;
                    cnt      <= CNT_MAX;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> !expire_o); // R10
    AST_REARM_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |-> (cnt == CNT_MAX)); // R10
endmodule

// File: rtl/wdt_keyctl.sv
// Module: wdt_keyctl
// Decodes key writes (start, refresh, unlock), keeps the sticky run state
// and the unlock state, and holds the divider and reload registers. Each
// register has a busy tracker that blocks further writes for HOLD_TICKS
// prescaled ticks. Assumes one bus write per cycle at most.
module wdt_keyctl
    import wdt_pkg::*;
#(
    parameter int CNT_W      = 12,
    parameter int CODE_W     = 3,
    parameter int HOLD_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_start_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_sel_i,
    input  logic [BUS_W-1:0]  wr_data_i,
    input  logic              tick_i,
    output logic              running_o,
    output logic              feed_o,
    output logic              restart_o,
    output logic [CODE_W-1:0] code_o,
    output logic [CNT_W-1:0]  reload_o,
    output logic [1:0]        busy_o
);
    localparam int NUM_CFG = 2;
    localparam int HOLD_W  = $clog2(HOLD_TICKS + 1);

    logic               unlocked;
    logic               key_wr;
    logic [NUM_CFG-1:0] cfg_hit;

    assign key_wr    = wr_en_i && (wr_sel_i == SEL_KEY);
    assign feed_o    = key_wr && (wr_data_i == KEY_FEED);
    assign restart_o = feed_o || (key_wr && (wr_data_i == KEY_RUN));

    // Run state: preset by the strap at reset, set by the start key, never cleared.
    always_ff @(posedge clk) begin
        if (!rst_n)                                running_o <= hw_start_i;
        else if (key_wr && wr_data_i == KEY_RUN)   running_o <= 1'b1;
    end

    // Unlock state: opened only by the unlock key, closed by any other key.
    always_ff @(posedge clk) begin
        if (!rst_n)      unlocked <= 1'b0;
        else if (key_wr) unlocked <= (wr_data_i == KEY_OPEN);
    end

    // One busy tracker per configuration register.
    for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
        localparam logic [1:0] MY_SEL = (g == 0) ? SEL_DIV : SEL_RELOAD;
        logic [HOLD_W-1:0] hold_cnt;

        assign cfg_hit[g] = wr_en_i && unlocked && !busy_o[g] && (wr_sel_i == MY_SEL);
        assign busy_o[g]  = (hold_cnt != '0);

        // Hold window: loaded on an accepted write, drained by prescaled ticks.
        always_ff @(posedge clk) begin
            if (!rst_n)                       hold_cnt <= '0;
            else if (cfg_hit[g])              hold_cnt <= HOLD_W'(HOLD_TICKS);
            else if (tick_i && busy_o[g])     hold_cnt <= hold_cnt - 1'b1;
        end
    end

    // Configuration registers, written only through an accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_o   <= '0;
            reload_o <= '1;
        end else begin
            if (cfg_hit[0]) code_o   <= wr_data_i[CODE_W-1:0];
            if (cfg_hit[1]) reload_o <= wr_data_i[CNT_W-1:0];
        end
    end

    AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        running_o |=> running_o); // R10
    AST_OTHER_KEY_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (key_wr && wr_data_i != KEY_OPEN) |=> !unlocked); // R6
    AST_LOCKED_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i == SEL_DIV && !unlocked) |=> $stable(code_o)); // R5
    AST_LOCKED_RELOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i == SEL_RELOAD && !unlocked) |=> $stable(reload_o)); // R5
    AST_BUSY_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i == SEL_DIV && busy_o[0]) |=> $stable(code_o)); // R8
    AST_BUSY_RELOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i == SEL_RELOAD && busy_o[1]) |=> $stable(reload_o)); // R8
endmodule

// File: rtl/keyed_wdt.sv
// Module: keyed_wdt
// Top of the key-protected watchdog. Joins the key/config control, the
// prescaler and the timeout counter, and provides a combinational read path.
// Assumes the whole block runs on the watchdog's own clock.
module keyed_wdt
    import wdt_pkg::*;
#(
    parameter int CNT_W      = 12,
    parameter int CODE_W     = 3,
    parameter int HOLD_TICKS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_start_i,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_sel_i,
    input  logic [BUS_W-1:0] wr_data_i,
    input  logic [1:0]       rd_sel_i,
    output logic [BUS_W-1:0] rd_data_o,
    output logic             wdt_rst_o
);
    logic              running;
    logic              feed;
    logic              restart;
    logic              tick;
    logic [CODE_W-1:0] code;
    logic [CNT_W-1:0]  reload;
    logic [1:0]        busy;

    wdt_keyctl #(.CNT_W(CNT_W), .CODE_W(CODE_W), .HOLD_TICKS(HOLD_TICKS)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .hw_start_i (hw_start_i),
        .wr_en_i    (wr_en_i),
        .wr_sel_i   (wr_sel_i),
        .wr_data_i  (wr_data_i),
        .tick_i     (tick),
        .running_o  (running),
        .feed_o     (feed),
        .restart_o  (restart),
        .code_o     (code),
        .reload_o   (reload),
        .busy_o     (busy)
    );

    wdt_prescaler #(.CODE_W(CODE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (restart),
        .code_i  (code),
        .tick_o  (tick)
    );

    wdt_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (running),
        .tick_i     (tick),
        .load_i     (feed),
        .load_val_i (reload),
        .expire_o   (wdt_rst_o)
    );

    // Register read mux; the key register reads as zero.
    always_comb begin
        case (rd_sel_i)
            SEL_DIV:    rd_data_o = BUS_W'(code);
            SEL_RELOAD: rd_data_o = BUS_W'(reload);
            SEL_STAT:   rd_data_o = BUS_W'(busy);
            default:    rd_data_o = '0;
        endcase
    end

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !wdt_rst_o); // R3
endmodule

// File: tb/keyed_wdt_test.sv
`timescale 1ns/1ps
module keyed_wdt_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hw_start = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'h0;
    logic [1:0]  rd_sel = 2'd0;
    logic [15:0] rd_data;
    logic        pulse;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    keyed_wdt uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .hw_start_i (hw_start),
        .wr_en_i    (wr_en),
        .wr_sel_i   (wr_sel),
        .wr_data_i  (wr_data),
        .rd_sel_i   (rd_sel),
        .rd_data_o  (rd_data),
        .wdt_rst_o  (pulse)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input bit strap);
        @(negedge clk);
        hw_start = strap;
        rst_n    = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [15:0] val);
        rd_sel = sel;
        #1;
        val = rd_data;
    endtask

    // Checks that the pulse is low for n-1 samples and high on the n-th.
    task automatic wait_pulse(input int n, input string tag);
        int early = 0;
        for (int i = 1; i < n; i++) begin
            @(negedge clk);
            if (pulse) early++;
        end
        @(negedge clk);
        check(early == 0 && pulse === 1'b1, tag, early * 2 + int'(pulse), 1);
    endtask

    task automatic wait_idle(input int bit_idx, input int bound, input string tag);
        logic [15:0] v;
        int waited = 0;
        rd(2'd3, v);
        while (v[bit_idx] && waited < bound) begin
            @(negedge clk);
            waited++;
            rd(2'd3, v);
        end
        check(!v[bit_idx], tag, waited, bound);
    endtask

    task automatic cfg(input logic [1:0] sel, input logic [15:0] data);
        wr(2'd0, 16'h5555);
        wr(sel, data);
        wait_idle(int'(sel) - 1, 600, "R8 busy release");
    endtask

    task automatic t_reset_idle();
        logic [15:0] v;
        int seen = 0;
        do_reset(1'b0);
        rd(2'd1, v); check(v == 16'h0,   "R1 divider reset", v, 0);
        rd(2'd2, v); check(v == 16'hFFF, "R1 reload reset", v, 16'hFFF);
        rd(2'd3, v); check(v == 16'h0,   "R1 status reset", v, 0);
        for (int i = 0; i < 17000; i++) begin
            @(negedge clk);
            if (pulse) seen++;
        end
        check(seen == 0, "R3 idle no pulse", seen, 0);
    endtask

    task automatic t_lock();
        logic [15:0] v;
        do_reset(1'b0);
        wr(2'd1, 16'd5);
        rd(2'd1, v); check(v == 16'd0, "R5 locked divider write", v, 0);
        wr(2'd2, 16'h010);
        rd(2'd2, v); check(v == 16'hFFF, "R5 locked reload write", v, 16'hFFF);
        cfg(2'd1, 16'd3);
        rd(2'd1, v); check(v == 16'd3, "R5 unlocked divider write", v, 3);
        wr(2'd0, 16'h5555);
        wr(2'd0, 16'h1234);
        wr(2'd1, 16'd6);
        rd(2'd1, v); check(v == 16'd3, "R6 relock by other key", v, 3);
        wr(2'd0, 16'h5555);
        wr(2'd0, 16'hAAAA);
        wr(2'd2, 16'h010);
        rd(2'd2, v); check(v == 16'hFFF, "R6 relock by refresh", v, 16'hFFF);
        cfg(2'd2, 16'h010);
        rd(2'd2, v); check(v == 16'h010, "R5 unlocked reload write", v, 16'h010);
    endtask

    task automatic t_status();
        logic [15:0] v;
        do_reset(1'b0);
        wr(2'd0, 16'h5555);
        wr(2'd1, 16'd2);
        rd(2'd3, v); check(v == 16'h1, "R8 divider busy set", v, 1);
        wr(2'd1, 16'd4);
        rd(2'd1, v); check(v == 16'd2, "R8 write dropped while busy", v, 2);
        wait_idle(0, 2 * 16 + 2, "R8 divider busy clears in 2 ticks");
        wr(2'd1, 16'd4);
        rd(2'd1, v); check(v == 16'd4, "R8 write after release", v, 4);
        wait_idle(0, 600, "R8 divider busy release");
        wr(2'd2, 16'h123);
        rd(2'd3, v); check(v == 16'h2, "R8 reload busy set", v, 2);
        wr(2'd2, 16'h456);
        rd(2'd2, v); check(v == 16'h123, "R8 reload write dropped while busy", v, 16'h123);
        wait_idle(1, 2 * 64 + 2, "R8 reload busy clears in 2 ticks");
    endtask

    task automatic t_start_feed();
        do_reset(1'b0);
        wr(2'd0, 16'hCCCC);
        wait_pulse(4 * 4096, "R2 start timeout");
        cfg(2'd2, 16'h020);
        wr(2'd0, 16'hAAAA);
        wait_pulse(4 * 33, "R4 refresh timeout");
    endtask

    task automatic t_sticky();
        do_reset(1'b0);
        wr(2'd0, 16'hCCCC);
        cfg(2'd2, 16'h000);
        wr(2'd0, 16'h0000);
        wr(2'd0, 16'hAAAA);
        wait_pulse(4, "R10 running after stray key");
        @(negedge clk);
        check(pulse === 1'b0, "R10 single-cycle pulse", int'(pulse), 0);
        wait_pulse(4 * 4096 - 1, "R10 rearm from maximum");
    endtask

    task automatic t_ratio();
        do_reset(1'b0);
        wr(2'd0, 16'hCCCC);
        cfg(2'd2, 16'h000);
        for (int c = 0; c < 8; c++) begin
            int d;
            d = 4 << ((c > 6) ? 6 : c);
            cfg(2'd1, 16'(c));
            wr(2'd0, 16'hAAAA);
            wait_pulse(d, $sformatf("R7 ratio code %0d", c));
        end
    endtask

    task automatic t_strap();
        do_reset(1'b1);
        wait_pulse(4 * 4096, "R9 strap start timeout");
        hw_start = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run hung actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        t_reset_idle();
        t_lock();
        t_status();
        t_start_feed();
        t_sticky();
        t_ratio();
        t_strap();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end
endmodule